// File: doc/BRIEF.md
# Calibration Trim-DAC Serial Loader

This block sets the trim voltages that calibrate a bank of analog outputs. A host request names a calibration channel (0 to 20) and gives a data word. The block builds an 11-bit frame and shifts it out on one data/clock pair that all three 8-channel trim DACs share. It then pulses a 2-bit load-select field so that only the addressed DAC latches the frame. Each analog output owns two channels, offset first and then gain. Channel 12 trims the 2.5 V reference offset.

The host presents `req_valid` together with a channel and a word. The request is taken on a rising edge where `req_ready` is high. The block also keeps a copy of the last value accepted for every channel, so software can read back its settings without touching the DACs. The length of each serial clock phase is set in system clock cycles by `phase_len`. This lets slow DAC timing be met.

Top module: `trimdac_loader`

## Requirements
- R1: An accepted request sends exactly 11 serial bits, most significant first. Frame bits 10:8 carry the channel index modulo 8, and bits 7:0 carry the trim value.
- R2: The serial clock is low while idle. Serial data changes only while the clock is low, and it stays stable for as long as the clock is high.
- R3: Every low phase and every high phase of the serial clock lasts `max(phase_len,1)` system cycles. A `phase_len` of 0 behaves as 1.
- R4: After the last bit, `load_sel` equals (channel / 8) + 1 for one phase: 1, 2 or 3 selects DAC 0, 1 or 2. It then returns to 0, which loads no DAC. It is never nonzero while the serial clock is high.
- R5: Only the low 8 bits of the 16-bit request word are used. The upper bits have no effect on the frame or on the readback.
- R6: `req_ready` drops on the edge that accepts a request. It stays low for exactly 23 phases (11 low phases, 11 high phases, 1 load phase) and rises in the same cycle that `load_sel` returns to 0.
- R7: A request with a channel above 20 is rejected. `req_ready` stays high, no serial clock or load pulse appears, and no readback entry changes.
- R8: `rd_value` returns the last value accepted for `rd_chan`, and it is updated by the accepting edge. After reset every entry reads 0. A `rd_chan` above 20 reads 0.
- R9: After reset, `req_ready` is 1 and `ser_clk`, `ser_data` and `load_sel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_len | input | 8 | System cycles per serial clock phase (0 acts as 1) |
| req_valid | input | 1 | Host write request |
| req_ready | output | 1 | Idle and able to accept a request |
| req_chan | input | 5 | Calibration channel index |
| req_word | input | 16 | Host data word; low 8 bits are the trim value |
| rd_chan | input | 5 | Readback channel index |
| rd_value | output | 8 | Last trim value accepted for `rd_chan` |
| ser_data | output | 1 | Shared serial data to the trim DACs |
| ser_clk | output | 1 | Shared serial clock to the trim DACs |
| load_sel | output | 2 | Load strobe select: 0 none, 1..3 DAC 0..2 |

## Verification
Two functions can fall in the same cycle: a cache write that accepts a request, and a readback of that same channel. The bench provokes this by pointing `rd_chan` at the channel being written before the request is presented. It then samples `rd_value` in the first cycle after the accepting edge and expects the new, masked value there. A second overlap occurs when `load_sel` clears and `req_ready` rises. The bench judges it by counting busy cycles, which must equal exactly 23 phases, and by checking that the load field lasted exactly one phase.

// File: rtl/trimdac_loader.sv
module trimdac_loader #(
  parameter int NUM_CH = 21,
  parameter int CH_W   = 5,
  parameter int WORD_W = 16,
  parameter int VAL_W  = 8,
  parameter int SUB_W  = 3,
  parameter int SEL_W  = 2,
  parameter int PH_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   phase_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [WORD_W-1:0] req_word,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [VAL_W-1:0]  rd_value,
  output logic              ser_data,
  output logic              ser_clk,
  output logic [SEL_W-1:0]  load_sel
);
  localparam int FRAME_W = SUB_W + VAL_W;
  localparam int BIT_W   = $clog2(FRAME_W);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_LOAD} state_t;

  state_t             state;
  logic [FRAME_W-1:0] frame;
  logic [BIT_W-1:0]   bits_left;
  logic [PH_W-1:0]    tmr;
  logic [SEL_W-1:0]   sel_q;
  logic [VAL_W-1:0]   cache [NUM_CH];

  wire              chan_ok   = req_chan < CH_W'(NUM_CH);
  wire              accept    = req_valid && (state == S_IDLE) && chan_ok;
  wire [PH_W-1:0]   ph_last   = (phase_len == '0) ? '0 : phase_len - 1'b1;
  wire              phase_end = (tmr == ph_last);
  wire [CH_W-1:0]   grp       = req_chan >> SUB_W;

  assign req_ready = (state == S_IDLE);
  assign ser_clk   = (state == S_HIGH);
  assign ser_data  = ((state == S_LOW) || (state == S_HIGH)) && frame[FRAME_W-1];
  assign load_sel  = (state == S_LOAD) ? sel_q : '0;
  assign rd_value  = (rd_chan < CH_W'(NUM_CH)) ? cache[rd_chan] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      frame     <= '0;
      bits_left <= '0;
      tmr       <= '0;
      sel_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          frame     <= {req_chan[SUB_W-1:0], req_word[VAL_W-1:0]};
          sel_q     <= SEL_W'(grp) + SEL_W'(1);
          bits_left <= BIT_W'(FRAME_W - 1);
          tmr       <= '0;
          state     <= S_LOW;
        end
        S_LOW: if (phase_end) begin
          tmr   <= '0;
          state <= S_HIGH;
        end else tmr <= tmr + 1'b1;
        S_HIGH: if (phase_end) begin
          tmr <= '0;
          if (bits_left == '0) state <= S_LOAD;
          else begin
            bits_left <= bits_left - 1'b1;
            frame     <= frame << 1;
            state     <= S_LOW;
          end
        end else tmr <= tmr + 1'b1;
        default: if (phase_end) begin
          tmr   <= '0;
          state <= S_IDLE;
        end else tmr <= tmr + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) cache[i] <= '0;
    end else if (accept) begin
      cache[req_chan] <= req_word[VAL_W-1:0];
    end
  end

  // R2
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R4
  load_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != '0) |-> !ser_clk);

  // R6
  busy_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_sel != '0) |-> !req_ready);

  // R6
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chan < CH_W'(NUM_CH)) |=> !req_ready);

  // R7
  reject_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_chan >= CH_W'(NUM_CH)) |=> req_ready);

  // R4
  load_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_sel) != '0 && load_sel == '0) |-> req_ready);
endmodule

// File: tb/test_trimdac_loader.sv
module test_trimdac_loader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  phase_len = 8'd1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [4:0]  req_chan = '0;
  logic [15:0] req_word = '0;
  logic [4:0]  rd_chan = '0;
  logic [7:0]  rd_value;
  logic        ser_data, ser_clk;
  logic [1:0]  load_sel;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  trimdac_loader i_trimdac_loader (
    .clk(clk), .rst_n(rst_n), .phase_len(phase_len),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_word(req_word),
    .rd_chan(rd_chan), .rd_value(rd_value),
    .ser_data(ser_data), .ser_clk(ser_clk), .load_sel(load_sel));

  always #4 clk = ~clk;

  logic [10:0] cap;
  int nbits, hrun, hbad, lsel_len, busy, sclk_seen;
  logic [1:0] lsel_val;
  logic prev_sclk = 0;
  int exp_p;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (ser_clk && !prev_sclk) begin cap = {cap[9:0], ser_data}; nbits++; end
      if (ser_clk) begin hrun++; sclk_seen++; end
      else if (prev_sclk) begin if (hrun != exp_p) hbad++; hrun = 0; end
      if (load_sel != 0) begin lsel_val = load_sel; lsel_len++; end
      if (!req_ready) busy++;
      prev_sclk = ser_clk;
    end
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap = 0; nbits = 0; hrun = 0; hbad = 0; lsel_len = 0; busy = 0;
    sclk_seen = 0; lsel_val = 0;
  endtask

  task automatic do_write(input int ch, input int word, input int plen);
    int p;
    p = (plen == 0) ? 1 : plen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    phase_len = 8'(plen);
    exp_p = p;
    clear_mon();
    rd_chan = 5'(ch);
    req_chan = 5'(ch);
    req_word = 16'(word);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R8 same-cycle readback", rd_value, word & 8'hFF);
    while (!req_ready) @(negedge clk);
    #1;
    chk("R1 frame", cap, ((ch % 8) << 8) | (word & 8'hFF));
    chk("R1 bit count", nbits, 11);
    chk("R3 high phase length", hbad, 0);
    chk("R4 load select", lsel_val, ch / 8 + 1);
    chk("R4 load length", lsel_len, p);
    chk("R6 busy cycles", busy, 23 * p);
    chk("R2 idle clock low", ser_clk, 0);
    chk("R4 load released", load_sel, 0);
  endtask

  task automatic t_reset();
    chk("R9 ready", req_ready, 1);
    chk("R9 ser_clk", ser_clk, 0);
    chk("R9 ser_data", ser_data, 0);
    chk("R9 load_sel", load_sel, 0);
    for (int c = 0; c < 21; c++) begin
      rd_chan = 5'(c); #1;
      chk("R8 reset cache", rd_value, 0);
    end
  endtask

  task automatic t_reject(input int ch);
    int rdy_low;
    rdy_low = 0;
    @(negedge clk);
    clear_mon();
    req_chan = 5'(ch); req_word = 16'h0077; req_valid = 1;
    repeat (5) begin
      @(negedge clk);
      if (!req_ready) rdy_low++;
    end
    req_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 ready kept", rdy_low, 0);
    chk("R7 no serial clock", sclk_seen, 0);
    chk("R7 no load", lsel_len, 0);
    rd_chan = 5'd0; #1;
    chk("R7 cache ch0 unchanged", rd_value, 8'hA5);
    rd_chan = 5'd20; #1;
    chk("R7 cache ch20 unchanged", rd_value, 8'hFF);
    rd_chan = 5'(ch); #1;
    chk("R8 out-of-range readback", rd_value, 0);
  endtask

  task automatic t_readback();
    rd_chan = 5'd0;  #1; chk("R8 ch0",  rd_value, 8'hA5);
    rd_chan = 5'd12; #1; chk("R5 ch12 masked", rd_value, 8'h3C);
    rd_chan = 5'd7;  #1; chk("R8 ch7",  rd_value, 8'h5A);
    rd_chan = 5'd1;  #1; chk("R8 ch1 untouched", rd_value, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    do_write(0, 16'h00A5, 1);
    do_write(12, 16'h913C, 3);
    do_write(20, 16'h00FF, 0);
    do_write(7, 16'hFF5A, 2);
    t_reject(21);
    t_reject(31);
    t_readback();
    do_write(0, 16'h0100, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule